// File: doc/BRIEF.md
# I2C Slave to Wishbone Register Bridge

This block is an I2C target that turns serial bus traffic into cycles on an internal Wishbone bus with 8-bit addresses and 8-bit data. It runs entirely on the system clock. The incoming SCL and SDA lines pass through synchronizer flops. SDA is driven as an open-drain pair: a data bit plus an active-high output enable. The 7-bit address the block answers to arrives on an input port.

A write transaction carries the target address byte, then one byte that sets the internal register pointer, then any number of data bytes. Each data byte becomes one Wishbone write, and the pointer advances after every write. A read works in two parts. A write first sets the pointer. A repeated START with the read bit then streams bytes from consecutive locations. Every START launches a Wishbone read of the current pointer, so the first byte is already held when the master starts clocking. Each later byte is fetched as soon as the previous one has been fully shifted out.

Two state machines split the work. One follows the serial protocol phases: idle, address, write, read, and wait after a refused byte. The other sequences the Wishbone cycles: prefetch, address wait, write data, move data and read data. A small datapath holds the edge detectors, the bit counter, the shift register, the pointer and the bus request logic.

Top module: `i2c_wb_bridge`

## Requirements
- R1: After reset the block leaves SDA released (sdaOe = 0) and keeps wbCyc and wbStb low.
- R2: An address byte whose upper 7 bits equal myAddr is acknowledged by pulling SDA low during the ninth clock. Any other address is not acknowledged, and the following bytes of that transaction produce neither acknowledge nor Wishbone cycle.
- R3: In a write transaction, the first byte after the address loads the register pointer. Each later byte is acknowledged and issues one Wishbone write (wbWe = 1) of that byte. The writes go to consecutive addresses, starting at the loaded pointer.
- R4: A Wishbone cycle raises wbCyc and wbStb together, keeps them high until wbAck is sampled high, and drops both on the clock edge where wbAck is seen. wbSel follows wbStb.
- R5: After a repeated START with the read bit set (bit 0 = 1), the block returns the byte at the pointer, MSB first. Each byte the master acknowledges is followed by the byte at the next address.
- R6: After the master refuses a read byte (SDA high on the ninth clock), the block keeps SDA released for the rest of the transaction, whatever SCL does.
- R7: The register pointer survives STOP. It is left one past the last location written or read, and a later transaction's first data byte replaces it.
- R8: Every START condition launches a Wishbone read of the current pointer before the address byte is complete.
- R9: The block changes the level it drives on SDA only while SCL is low.
- R10: wbAdr, wbWe and wbDatO stay constant for the whole of a Wishbone cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| myAddr | input | SA_W | Address this target answers to |
| sdaOut | output | 1 | Level driven onto SDA while enabled |
| sdaOe | output | 1 | SDA drive enable, active high |
| wbAdr | output | ADDR_W | Wishbone address |
| wbDatO | output | DATA_W | Wishbone write data |
| wbDatI | input | DATA_W | Wishbone read data |
| wbWe | output | 1 | Wishbone write enable |
| wbStb | output | 1 | Wishbone strobe |
| wbSel | output | 1 | Wishbone select, same as strobe |
| wbCyc | output | 1 | Wishbone cycle |
| wbAck | input | 1 | Wishbone acknowledge |

## Verification
The bench builds the bridge with 8-bit address and data, a 7-bit target address of 0x2A, and three synchronizer stages instead of the default two. The deeper synchronizer stretches the delay from a bus edge to the reaction, which tests whether acknowledge and read bits still land inside the low half of SCL when each SCL phase lasts ten system clocks. With 8-bit data the bench can check pointer load, three-byte write and read bursts, prefetch on START, and the refused-byte release, all against a byte-wide memory model.

// File: rtl/i2c_wb_pkg.sv
package i2c_wb_pkg;

  // serial protocol phases
  typedef enum logic [2:0] {
    P_IDLE,
    P_ADDR,
    P_WRITE,
    P_READ,
    P_WAIT
  } protoSt_t;

  // bus cycle sequencing
  typedef enum logic [2:0] {
    C_IDLE,
    C_WT0,
    C_ADDR,
    C_WDATA,
    C_RDATA,
    C_MVDT
  } cycSt_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic incAddr;
    logic rdReq;
    logic wrReq;
    logic drvAck;
    logic drvData;
  } ctlStrb_t;

  // events from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic sdaBit;
    logic wbDone;
  } busEv_t;

endpackage

// File: rtl/i2c_wb_sync.sv
module i2c_wb_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stage;

  always_ff @(posedge clk) begin
    if (!rstN) stage[0] <= RST_VAL;
    else       stage[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) stage[g] <= RST_VAL;
      else       stage[g] <= stage[g-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/i2c_wb_dpath.sv
module i2c_wb_dpath
  import i2c_wb_pkg::*;
#(
  parameter  int ADDR_W      = 8,
  parameter  int DATA_W      = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int CNT_W       = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctlStrb_t          strb,
  output busEv_t            ev,
  output logic [DATA_W-1:0] rxByte,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              sdaOut,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] wbAdr,
  output logic [DATA_W-1:0] wbDatO,
  input  logic [DATA_W-1:0] wbDatI,
  output logic              wbWe,
  output logic              wbStb,
  output logic              wbSel,
  output logic              wbCyc,
  input  logic              wbAck
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

  logic sclS, sdaS, sclPrev, sdaPrev;
  logic [DATA_W-1:0] rxSh, txByte, txShifted;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] adrR;
  logic [DATA_W-1:0] datR;
  logic cycR, weR, doneR, oeR, outR;
  logic sclRise, sclFall, startDet, stopDet;

  i2c_wb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sclSync_i (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS)
  );
  i2c_wb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sdaSync_i (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  // bit counter and receive shift register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      rxSh <= '0;
    end else if (startDet || stopDet) begin
      cnt <= '0;
    end else if (sclRise) begin
      if (cnt == FULL_CNT) begin
        cnt <= '0;
      end else begin
        cnt  <= cnt + 1'b1;
        rxSh <= {rxSh[DATA_W-2:0], sdaS};
      end
    end
  end

  // register pointer
  always_ff @(posedge clk) begin
    if (!rstN)              adrR <= '0;
    else if (strb.loadAddr) adrR <= ADDR_W'(rxSh);
    else if (strb.incAddr)  adrR <= adrR + 1'b1;
  end

  // bus cycle engine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycR   <= 1'b0;
      weR    <= 1'b0;
      datR   <= '0;
      doneR  <= 1'b0;
      txByte <= '0;
    end else begin
      doneR <= 1'b0;
      if (cycR) begin
        if (wbAck) begin
          cycR  <= 1'b0;
          doneR <= 1'b1;
          if (!weR) txByte <= wbDatI;
        end
      end else if (strb.rdReq) begin
        cycR <= 1'b1;
        weR  <= 1'b0;
      end else if (strb.wrReq) begin
        cycR <= 1'b1;
        weR  <= 1'b1;
        datR <= rxSh;
      end
    end
  end

  // serial output, updated on SCL low only
  assign txShifted = txByte << cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oeR  <= 1'b0;
      outR <= 1'b1;
    end else if (startDet || stopDet) begin
      oeR  <= 1'b0;
      outR <= 1'b1;
    end else if (sclFall) begin
      if (strb.drvAck) begin
        oeR  <= 1'b1;
        outR <= 1'b0;
      end else if (strb.drvData) begin
        oeR  <= 1'b1;
        outR <= txShifted[DATA_W-1];
      end else begin
        oeR  <= 1'b0;
        outR <= 1'b1;
      end
    end
  end

  assign ev.sclRise  = sclRise;
  assign ev.sclFall  = sclFall;
  assign ev.startDet = startDet;
  assign ev.stopDet  = stopDet;
  assign ev.sdaBit   = sdaS;
  assign ev.wbDone   = doneR;

  assign rxByte = rxSh;
  assign bitCnt = cnt;
  assign sdaOut = outR;
  assign sdaOe  = oeR;
  assign wbAdr  = adrR;
  assign wbDatO = datR;
  assign wbWe   = weR;
  assign wbCyc  = cycR;
  assign wbStb  = cycR;
  assign wbSel  = cycR;

endmodule

// File: rtl/i2c_wb_ctrl.sv
module i2c_wb_ctrl
  import i2c_wb_pkg::*;
#(
  parameter  int DATA_W = 8,
  parameter  int SA_W   = 7,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [SA_W-1:0]   myAddr,
  output ctlStrb_t          strb
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

  protoSt_t protoSt;
  cycSt_t   cycSt, cycNext;
  logic     firstByte, rdPend;
  logic     byteFull, ackClk, lastBitRise, addrHit, rwBit;
  logic     toWdata, takeFirst, goRead;

  assign byteFull    = (bitCnt == FULL_CNT);
  assign ackClk      = ev.sclRise & byteFull;
  assign lastBitRise = ev.sclRise & (bitCnt == LAST_CNT);
  assign addrHit     = (rxByte[DATA_W-1 -: SA_W] == myAddr);
  assign rwBit       = rxByte[0];

  // protocol phase machine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      protoSt <= P_IDLE;
    end else if (ev.stopDet) begin
      protoSt <= P_IDLE;
    end else if (ev.startDet) begin
      protoSt <= P_ADDR;
    end else begin
      case (protoSt)
        P_ADDR:  if (ackClk) protoSt <= addrHit ? (rwBit ? P_READ : P_WRITE) : P_IDLE;
        P_READ:  if (ackClk && ev.sdaBit) protoSt <= P_WAIT;
        default: protoSt <= protoSt;
      endcase
    end
  end

  // bus cycle machine
  always_comb begin
    strb      = '0;
    cycNext   = cycSt;
    toWdata   = 1'b0;
    takeFirst = 1'b0;
    goRead    = 1'b0;
    strb.drvAck  = byteFull && ((protoSt == P_ADDR && addrHit) || protoSt == P_WRITE);
    strb.drvData = !byteFull && (protoSt == P_READ);
    if (ev.stopDet) begin
      cycNext = C_IDLE;
    end else if (ev.startDet) begin
      cycNext     = C_WT0;
      strb.rdReq  = 1'b1;
    end else begin
      strb.rdReq = rdPend;
      case (cycSt)
        C_WT0, C_ADDR: begin
          if (protoSt == P_ADDR && ackClk) begin
            if (!addrHit)   cycNext = C_IDLE;
            else if (rwBit) cycNext = C_RDATA;
            else begin
              cycNext = C_WDATA;
              toWdata = 1'b1;
            end
          end else if (cycSt == C_WT0 && ev.wbDone) begin
            cycNext = C_ADDR;
          end
        end
        C_WDATA: begin
          if (protoSt == P_WRITE && ackClk) begin
            if (firstByte) begin
              strb.loadAddr = 1'b1;
              takeFirst     = 1'b1;
            end else begin
              strb.wrReq = 1'b1;
              cycNext    = C_MVDT;
            end
          end
        end
        C_MVDT: begin
          if (ev.wbDone) begin
            strb.incAddr = 1'b1;
            cycNext      = C_WDATA;
          end
        end
        C_RDATA: begin
          if (protoSt == P_READ && lastBitRise) begin
            strb.incAddr = 1'b1;
            goRead       = 1'b1;
          end
        end
        default: cycNext = cycSt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycSt     <= C_IDLE;
      firstByte <= 1'b0;
      rdPend    <= 1'b0;
    end else begin
      cycSt  <= cycNext;
      rdPend <= goRead;
      if (toWdata)        firstByte <= 1'b1;
      else if (takeFirst) firstByte <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_wb_bridge.sv
module i2c_wb_bridge
  import i2c_wb_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SA_W        = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [SA_W-1:0]   myAddr,
  output logic              sdaOut,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] wbAdr,
  output logic [DATA_W-1:0] wbDatO,
  input  logic [DATA_W-1:0] wbDatI,
  output logic              wbWe,
  output logic              wbStb,
  output logic              wbSel,
  output logic              wbCyc,
  input  logic              wbAck
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  busEv_t            evBus;
  ctlStrb_t          strbBus;
  logic [DATA_W-1:0] rxByte;
  logic [CNT_W-1:0]  bitCnt;

  i2c_wb_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strb(strbBus), .ev(evBus), .rxByte(rxByte), .bitCnt(bitCnt),
    .sdaOut(sdaOut), .sdaOe(sdaOe),
    .wbAdr(wbAdr), .wbDatO(wbDatO), .wbDatI(wbDatI), .wbWe(wbWe),
    .wbStb(wbStb), .wbSel(wbSel), .wbCyc(wbCyc), .wbAck(wbAck)
  );

  i2c_wb_ctrl #(
    .DATA_W(DATA_W), .SA_W(SA_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .ev(evBus), .rxByte(rxByte),
    .bitCnt(bitCnt), .myAddr(myAddr), .strb(strbBus)
  );

endmodule

// File: rtl/i2c_wb_bridge_chk.sv
module i2c_wb_bridge_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOut,
  input logic              sdaOe,
  input logic [ADDR_W-1:0] wbAdr,
  input logic [DATA_W-1:0] wbDatO,
  input logic              wbWe,
  input logic              wbStb,
  input logic              wbCyc,
  input logic              wbAck
);

  AST_CYC_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && !wbAck) |=> (wbCyc && wbStb));  // R4

  AST_CYC_DROPS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && wbAck) |=> (!wbCyc && !wbStb));  // R4

  AST_REQ_STABLE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && $past(wbCyc)) |-> ($stable(wbAdr) && $stable(wbWe) && $stable(wbDatO)));  // R10

  AST_SDA_MOVES_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) || (sdaOe && $changed(sdaOut))) |-> !sclIn);  // R9

endmodule

bind i2c_wb_bridge i2c_wb_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOut(sdaOut), .sdaOe(sdaOe),
  .wbAdr(wbAdr), .wbDatO(wbDatO), .wbWe(wbWe), .wbStb(wbStb),
  .wbCyc(wbCyc), .wbAck(wbAck)
);

// File: tb/i2c_wb_bridge_tb_top.sv
module i2c_wb_bridge_tb_top;

  localparam int Q = 10;
  localparam logic [6:0] SA = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOut, sdaOe, wbWe, wbStb, wbSel, wbCyc;
  logic [7:0] wbAdr, wbDatO;
  logic [7:0] wbDatI = 8'h00;
  logic wbAck = 1'b0;
  logic sdaBus;

  int total = 0;
  int bad = 0;
  int wrCnt = 0;
  int rdCnt = 0;
  int hsViol = 0;
  int stabViol = 0;
  int sdaViol = 0;
  bit finished = 1'b0;

  logic [7:0] mem [256];

  always #4 clk = ~clk;

  assign sdaBus = sdaM & ~(sdaOe & ~sdaOut);

  i2c_wb_bridge #(.ADDR_W(8), .DATA_W(8), .SA_W(7), .SYNC_STAGES(3)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .myAddr(SA),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .wbAdr(wbAdr), .wbDatO(wbDatO),
    .wbDatI(wbDatI), .wbWe(wbWe), .wbStb(wbStb), .wbSel(wbSel),
    .wbCyc(wbCyc), .wbAck(wbAck)
  );

  // wishbone memory model
  always @(posedge clk) begin
    if (!rstN) begin
      wbAck <= 1'b0;
    end else if (wbCyc && wbStb && !wbAck) begin
      wbAck <= 1'b1;
      if (wbWe) begin
        mem[wbAdr] <= wbDatO;
        wrCnt <= wrCnt + 1;
      end else begin
        wbDatI <= mem[wbAdr];
        rdCnt <= rdCnt + 1;
      end
    end else begin
      wbAck <= 1'b0;
    end
  end

  // port monitors sampled on falling edge
  logic pCyc = 1'b0, pAck = 1'b0, pWe = 1'b0, pOe = 1'b0, pOut = 1'b1;
  logic [7:0] pAdr = 8'h00, pDat = 8'h00;
  always @(negedge clk) begin
    if (rstN) begin
      if (wbStb != wbCyc || wbSel != wbStb) hsViol++;
      if (pCyc && !pAck && !wbCyc) hsViol++;
      if (pCyc && pAck && wbCyc) hsViol++;
      if (pCyc && wbCyc && (wbAdr != pAdr || wbWe != pWe || wbDatO != pDat)) stabViol++;
      if (sdaOe && (!pOe || sdaOut != pOut) && sclM) sdaViol++;
    end
    pCyc = wbCyc; pAck = wbAck; pWe = wbWe; pAdr = wbAdr; pDat = wbDatO;
    pOe = sdaOe; pOut = sdaOut;
  end

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    sdaM = 1'b0; waitQ(Q);
    sclM = 1'b0; waitQ(Q);
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    sdaM = 1'b1; waitQ(Q);
  endtask

  task automatic bitCycle(input logic txBit, output logic rxBit);
    sdaM = txBit; waitQ(Q);
    sclM = 1'b1;  waitQ(Q);
    rxBit = sdaBus; waitQ(Q);
    sclM = 1'b0;  waitQ(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackBit);
    logic dummy;
    for (int i = 7; i >= 0; i--) bitCycle(b[i], dummy);
    bitCycle(1'b1, ackBit);
  endtask

  task automatic recvByte(input logic masterAck, output logic [7:0] b);
    logic dummy;
    for (int i = 7; i >= 0; i--) bitCycle(1'b1, b[i]);
    bitCycle(~masterAck, dummy);
  endtask

  task automatic testReset();
    chk(sdaOe == 1'b0, "R1", "sdaOe after reset", int'(sdaOe), 0);
    chk(wbCyc == 1'b0 && wbStb == 1'b0, "R1", "cyc/stb after reset", int'(wbCyc), 0);
  endtask

  task automatic testWriteBurst();
    logic a;
    int rd0, wr0;
    rd0 = rdCnt;
    wr0 = wrCnt;
    i2cStart();
    chk(rdCnt == rd0 + 1, "R8", "prefetch read on START", rdCnt - rd0, 1);
    sendByte({SA, 1'b0}, a);
    chk(a == 1'b0, "R2", "address ack", int'(a), 0);
    sendByte(8'h10, a);
    chk(a == 1'b0 && wrCnt == wr0, "R3", "pointer byte acked, no write", wrCnt - wr0, 0);
    sendByte(8'h11, a); chk(a == 1'b0, "R3", "data ack 0", int'(a), 0);
    sendByte(8'h22, a); chk(a == 1'b0, "R3", "data ack 1", int'(a), 0);
    sendByte(8'h33, a); chk(a == 1'b0, "R3", "data ack 2", int'(a), 0);
    i2cStop();
    chk(wrCnt == wr0 + 3, "R3", "write count", wrCnt - wr0, 3);
    chk(mem[8'h10] == 8'h11, "R3", "mem[10]", int'(mem[8'h10]), 'h11);
    chk(mem[8'h11] == 8'h22, "R3", "mem[11]", int'(mem[8'h11]), 'h22);
    chk(mem[8'h12] == 8'h33, "R3", "mem[12]", int'(mem[8'h12]), 'h33);
  endtask

  task automatic testMismatch();
    logic a;
    int wr0;
    wr0 = wrCnt;
    i2cStart();
    sendByte({SA ^ 7'h01, 1'b0}, a);
    chk(a == 1'b1, "R2", "foreign address not acked", int'(a), 1);
    sendByte(8'h20, a);
    chk(a == 1'b1, "R2", "foreign byte 0 not acked", int'(a), 1);
    sendByte(8'h77, a);
    chk(a == 1'b1, "R2", "foreign byte 1 not acked", int'(a), 1);
    i2cStop();
    chk(wrCnt == wr0, "R2", "no write for foreign address", wrCnt - wr0, 0);
    chk(mem[8'h20] == (8'h20 ^ 8'hA5), "R2", "mem[20] untouched", int'(mem[8'h20]), 'h85);
  endtask

  task automatic testReadBurst();
    logic a, r;
    logic [7:0] b;
    i2cStart();
    sendByte({SA, 1'b0}, a);
    sendByte(8'h10, a);
    i2cStart();
    sendByte({SA, 1'b1}, a);
    chk(a == 1'b0, "R5", "read address ack", int'(a), 0);
    recvByte(1'b1, b); chk(b == 8'h11, "R5", "read byte 0", int'(b), 'h11);
    recvByte(1'b1, b); chk(b == 8'h22, "R5", "read byte 1", int'(b), 'h22);
    recvByte(1'b0, b); chk(b == 8'h33, "R5", "read byte 2", int'(b), 'h33);
    chk(sdaOe == 1'b0, "R6", "released after refusal", int'(sdaOe), 0);
    for (int i = 0; i < 9; i++) begin
      bitCycle(1'b1, r);
      chk(r == 1'b1, "R6", "bus stays high after refusal", int'(r), 1);
    end
    i2cStop();
  endtask

  task automatic testPointerPersist();
    logic a;
    logic [7:0] b;
    i2cStart();
    sendByte({SA, 1'b1}, a);
    recvByte(1'b0, b);
    chk(b == (8'h13 ^ 8'hA5), "R7", "read continues after last access", int'(b), 'hB6);
    i2cStop();
    i2cStart();
    sendByte({SA, 1'b0}, a);
    sendByte(8'h40, a);
    i2cStop();
    i2cStart();
    sendByte({SA, 1'b0}, a);
    sendByte(8'h50, a);
    sendByte(8'h99, a);
    i2cStop();
    chk(mem[8'h50] == 8'h99, "R7", "new pointer replaces old", int'(mem[8'h50]), 'h99);
    chk(mem[8'h40] == (8'h40 ^ 8'hA5), "R7", "old pointer not written", int'(mem[8'h40]), 'hE5);
  endtask

  task automatic testMonitors();
    chk(hsViol == 0, "R4", "handshake violations", hsViol, 0);
    chk(stabViol == 0, "R10", "request changed in cycle", stabViol, 0);
    chk(sdaViol == 0, "R9", "SDA moved with SCL high", sdaViol, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    waitQ(5);
    rstN = 1'b1;
    waitQ(5);
    testReset();
    testWriteBurst();
    testMismatch();
    testReadBurst();
    testPointerPersist();
    testMonitors();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule